// File: doc/BRIEF.md
# Idle Clock Gating and Power-Down Controller

This block runs low-power entry and exit for a processor core and the private second-level cache that shares its clock. While the core reports that it is idle in wait-for-interrupt, the block drops the enable of that shared clock. It raises the enable again when a wake event arrives: an interrupt, a hart reset request, or a flit-pending indication on any interconnect receive channel. A wake caused by interconnect traffic leaves gating disarmed until the core has left the idle state and entered it again. A debug halt request holds the clock on.

A second state machine runs the power-down handshake with an external power policy unit. On a power-off request it first asks the cache to flush. Once the flush is done, it waits for the core to go idle. Only then does it raise a no-operation indication, which tells the policy unit that the domain may be isolated and switched off. A power-on request and its acknowledge bring the machine back to normal running. Any wake event seen while the flush or the idle wait is in progress aborts the power-down.

All inputs except the flush completion come from other clock or power domains. Each passes through a synchronizer of `SYNC_STAGES` flops before any logic uses it.

Top module: `wfi_pwr_ctrl`

## Requirements
- R1: After reset, `clk_en_o` is 1, `flush_req_o` is 0 and `no_op_o` is 0.
- R2: When `core_wfi_i` rises with no wake source active, `clk_en_o` falls on the third rising clock edge after the input change and stays 0 while the core stays idle.
- R3: An interrupt (`irq_pend_i`) or hart reset request (`hart_rst_req_i`) raises a gated `clk_en_o` on the third rising edge. Once that source drops while the core is still idle, gating resumes.
- R4: A 1 on any single bit of `rx_flit_pend_i` (one bit per receive channel, NUM_RX_CH bits) raises a gated `clk_en_o` on the third rising edge.
- R5: After a traffic wake, `clk_en_o` stays 1 while `core_wfi_i` stays high, even once the flit-pending bits clear. Gating resumes only after `core_wfi_i` has gone low and then high again.
- R6: `dbg_halt_i` forces `clk_en_o` to 1 from the second rising edge after it rises, overriding gating. Gating returns once the request drops.
- R7: A power-off request (`pwr_off_req_i`) while running raises `flush_req_o` on the third rising edge. `flush_req_o` and `no_op_o` are never 1 together.
- R8: `no_op_o` rises only after `flush_done_i` has been seen and then the core is idle. If the core is already idle, `flush_req_o` falls one edge after `flush_done_i` and `no_op_o` rises one edge later.
- R9: A wake event during the flush or the idle wait aborts the power-down. `flush_req_o` falls, and `no_op_o` stays 0 even if the core goes idle in the same cycle that the wake is seen.
- R10: After `pwr_off_ack_i`, `no_op_o` stays 1 and power-off requests are ignored. `pwr_on_req_i` drops `no_op_o`. Power-off requests stay ignored until `pwr_on_ack_i` completes the power-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Active-low reset |
| core_wfi_i | input | 1 | Core is idle in wait-for-interrupt (async) |
| irq_pend_i | input | 1 | Interrupt pending (async) |
| hart_rst_req_i | input | 1 | Hart reset request, a wake source (async) |
| dbg_halt_i | input | 1 | Debug halt request (async) |
| rx_flit_pend_i | input | NUM_RX_CH | Flit pending, one bit per receive channel (async) |
| flush_done_i | input | 1 | Cache flush complete (synchronous) |
| pwr_off_req_i | input | 1 | Power-off request from policy unit (async) |
| pwr_off_ack_i | input | 1 | Power-off acknowledge from policy unit (async) |
| pwr_on_req_i | input | 1 | Power-on request from policy unit (async) |
| pwr_on_ack_i | input | 1 | Power-on acknowledge from policy unit (async) |
| clk_en_o | output | 1 | Enable for the core and cache clock gate |
| flush_req_o | output | 1 | Cache flush request |
| no_op_o | output | 1 | Domain quiescent, may be powered down |

## Verification
Two things can meet in one cycle: the idle-wait step of the power-down sequence and a traffic wake. The bench drives `core_wfi_i` high and a flit-pending bit high on the same clock. Both reach the logic through their synchronizers on the same edge. The abort must win, so the bench checks that `no_op_o` never rises and that `clk_en_o` stays 1 at that edge and several edges later. The same collision on the gating side, where the idle state and traffic arrive together, must not close the clock.

// File: rtl/wpc_pkg.sv
`timescale 1ns/1ps
package wpc_pkg;

    typedef enum logic [2:0] {
        PS_RUN     = 3'd0,
        PS_FLUSH   = 3'd1,
        PS_WAITWFI = 3'd2,
        PS_PDREQ   = 3'd3,
        PS_OFF     = 3'd4,
        PS_WAKE    = 3'd5
    } pwr_state_e;

    typedef struct packed {
        logic gated;
        logic rearm;
    } gate_regs_t;

    typedef struct packed {
        pwr_state_e st;
    } pwr_regs_t;

endpackage

// File: rtl/wpc_sync.sv
`timescale 1ns/1ps
module wpc_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout_o = chain_q[STAGES-1];
endmodule

// File: rtl/wpc_gate_ctl.sv
`timescale 1ns/1ps
module wpc_gate_ctl
    import wpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wfi_s,
    input  logic int_wake_s,
    input  logic traffic_s,
    input  logic dbg_s,
    output logic clk_en_o
);
    gate_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (r_q.gated) begin
            if (int_wake_s || traffic_s || !wfi_s) begin
                r_d.gated = 1'b0;
                r_d.rearm = r_q.rearm | traffic_s;
            end
        end else begin
            if (r_q.rearm && !wfi_s) begin
                r_d.rearm = 1'b0;
            end else if (wfi_s && !r_q.rearm && !int_wake_s && !traffic_s) begin
                r_d.gated = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign clk_en_o = !r_q.gated || dbg_s;
endmodule

// File: rtl/wpc_pwr_fsm.sv
`timescale 1ns/1ps
module wpc_pwr_fsm
    import wpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wfi_s,
    input  logic wake_s,
    input  logic flush_done_i,
    input  logic off_req_s,
    input  logic off_ack_s,
    input  logic on_req_s,
    input  logic on_ack_s,
    output logic flush_req_o,
    output logic no_op_o
);
    pwr_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            PS_RUN:     if (off_req_s) r_d.st = PS_FLUSH;
            PS_FLUSH: begin
                if (wake_s)            r_d.st = PS_RUN;
                else if (flush_done_i) r_d.st = PS_WAITWFI;
            end
            PS_WAITWFI: begin
                if (wake_s)            r_d.st = PS_RUN;
                else if (wfi_s)        r_d.st = PS_PDREQ;
            end
            PS_PDREQ:   if (off_ack_s) r_d.st = PS_OFF;
            PS_OFF:     if (on_req_s)  r_d.st = PS_WAKE;
            PS_WAKE:    if (on_ack_s)  r_d.st = PS_RUN;
            default:                   r_d.st = PS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q.st <= PS_RUN;
        else        r_q   <= r_d;
    end

    assign flush_req_o = (r_q.st == PS_FLUSH);
    assign no_op_o     = (r_q.st == PS_PDREQ) || (r_q.st == PS_OFF);
endmodule

// File: rtl/wfi_pwr_ctrl.sv
`timescale 1ns/1ps
module wfi_pwr_ctrl #(
    parameter int NUM_RX_CH   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 core_wfi_i,
    input  logic                 irq_pend_i,
    input  logic                 hart_rst_req_i,
    input  logic                 dbg_halt_i,
    input  logic [NUM_RX_CH-1:0] rx_flit_pend_i,
    input  logic                 flush_done_i,
    input  logic                 pwr_off_req_i,
    input  logic                 pwr_off_ack_i,
    input  logic                 pwr_on_req_i,
    input  logic                 pwr_on_ack_i,
    output logic                 clk_en_o,
    output logic                 flush_req_o,
    output logic                 no_op_o
);
    localparam int NCTL  = 8;
    localparam int NSYNC = NCTL + NUM_RX_CH;

    logic [NSYNC-1:0]     async_in, sync_out;
    logic                 wfi_s, irq_s, hrst_s, dbg_s;
    logic                 off_req_s, off_ack_s, on_req_s, on_ack_s;
    logic [NUM_RX_CH-1:0] flit_s;
    logic                 traffic_s, int_wake_s, wake_s;

    assign async_in = {rx_flit_pend_i, pwr_on_ack_i, pwr_on_req_i, pwr_off_ack_i,
                       pwr_off_req_i, dbg_halt_i, hart_rst_req_i, irq_pend_i, core_wfi_i};

    wpc_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (async_in),
        .dout_o (sync_out)
    );

    assign wfi_s     = sync_out[0];
    assign irq_s     = sync_out[1];
    assign hrst_s    = sync_out[2];
    assign dbg_s     = sync_out[3];
    assign off_req_s = sync_out[4];
    assign off_ack_s = sync_out[5];
    assign on_req_s  = sync_out[6];
    assign on_ack_s  = sync_out[7];
    assign flit_s    = sync_out[NSYNC-1:NCTL];

    assign traffic_s  = |flit_s;
    assign int_wake_s = irq_s | hrst_s;
    assign wake_s     = int_wake_s | traffic_s;

    wpc_gate_ctl u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .wfi_s      (wfi_s),
        .int_wake_s (int_wake_s),
        .traffic_s  (traffic_s),
        .dbg_s      (dbg_s),
        .clk_en_o   (clk_en_o)
    );

    wpc_pwr_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wfi_s        (wfi_s),
        .wake_s       (wake_s),
        .flush_done_i (flush_done_i),
        .off_req_s    (off_req_s),
        .off_ack_s    (off_ack_s),
        .on_req_s     (on_req_s),
        .on_ack_s     (on_ack_s),
        .flush_req_o  (flush_req_o),
        .no_op_o      (no_op_o)
    );
endmodule

// File: rtl/wpc_checker.sv
`timescale 1ns/1ps
module wpc_checker (
    input logic clk,
    input logic rst_n,
    input logic wfi_s,
    input logic dbg_s,
    input logic off_req_s,
    input logic clk_en_o,
    input logic flush_req_o,
    input logic no_op_o
);
    assert_dbg_forces_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_s |-> clk_en_o);

    assert_flush_noop_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush_req_o && no_op_o));

    assert_flush_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_req_o) |-> $past(off_req_s));

    assert_noop_needs_wfi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(no_op_o) |-> $past(wfi_s));

    assert_gate_needs_wfi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_en_o) |-> $past(wfi_s));
endmodule

bind wfi_pwr_ctrl wpc_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wfi_s       (wfi_s),
    .dbg_s       (dbg_s),
    .off_req_s   (off_req_s),
    .clk_en_o    (clk_en_o),
    .flush_req_o (flush_req_o),
    .no_op_o     (no_op_o)
);

// File: tb/sim_wfi_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_wfi_pwr_ctrl;
    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic core_wfi = 0, irq = 0, hrst = 0, dbg = 0, fdone = 0;
    logic off_req = 0, off_ack = 0, on_req = 0, on_ack = 0;
    logic [NCH-1:0] flit = '0;
    logic clk_en, flush_req, no_op;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    wfi_pwr_ctrl #(.NUM_RX_CH(NCH), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .core_wfi_i(core_wfi), .irq_pend_i(irq),
        .hart_rst_req_i(hrst), .dbg_halt_i(dbg), .rx_flit_pend_i(flit),
        .flush_done_i(fdone), .pwr_off_req_i(off_req), .pwr_off_ack_i(off_ack),
        .pwr_on_req_i(on_req), .pwr_on_ack_i(on_ack),
        .clk_en_o(clk_en), .flush_req_o(flush_req), .no_op_o(no_op)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 0;
        wait_n(3);
        chk(clk_en, 1'b1, "R1 clk_en after reset");
        chk(flush_req, 1'b0, "R1 flush_req after reset");
        chk(no_op, 1'b0, "R1 no_op after reset");
        rst_n = 1;
        wait_n(2);
        chk(clk_en, 1'b1, "R1 clk_en after release");
    endtask

    task automatic t_gate_irq;
        core_wfi = 1;
        wait_n(2);
        chk(clk_en, 1'b1, "R2 clk_en before third edge");
        wait_n(1);
        chk(clk_en, 1'b0, "R2 clk_en gated at third edge");
        wait_n(4);
        chk(clk_en, 1'b0, "R2 stays gated");
        irq = 1;
        wait_n(2);
        chk(clk_en, 1'b0, "R3 irq wake not before third edge");
        wait_n(1);
        chk(clk_en, 1'b1, "R3 irq wake at third edge");
        irq = 0;
        wait_n(4);
        chk(clk_en, 1'b0, "R3 regate after irq drops");
        hrst = 1;
        wait_n(3);
        chk(clk_en, 1'b1, "R3 hart reset wake");
        hrst = 0;
        core_wfi = 0;
        wait_n(4);
        chk(clk_en, 1'b1, "R3 running after core leaves idle");
    endtask

    task automatic t_traffic;
        for (int ch = 0; ch < NCH; ch++) begin
            core_wfi = 1;
            wait_n(4);
            chk(clk_en, 1'b0, "R4 gated before traffic");
            flit[ch] = 1'b1;
            wait_n(3);
            chk(clk_en, 1'b1, "R4 traffic wake on channel");
            flit[ch] = 1'b0;
            wait_n(5);
            chk(clk_en, 1'b1, "R5 no regate while still idle");
            core_wfi = 0;
            wait_n(4);
            chk(clk_en, 1'b1, "R5 running after leaving idle");
            core_wfi = 1;
            wait_n(4);
            chk(clk_en, 1'b0, "R5 regate after idle re-entry");
            core_wfi = 0;
            wait_n(4);
        end
    endtask

    task automatic t_debug;
        core_wfi = 1;
        wait_n(4);
        chk(clk_en, 1'b0, "R6 gated before debug");
        dbg = 1;
        wait_n(2);
        chk(clk_en, 1'b1, "R6 debug forces clock on");
        wait_n(3);
        chk(clk_en, 1'b1, "R6 debug holds clock on");
        dbg = 0;
        wait_n(3);
        chk(clk_en, 1'b0, "R6 gating returns after debug");
        core_wfi = 0;
        wait_n(4);
    endtask

    task automatic t_powerdown;
        off_req = 1;
        wait_n(2);
        chk(flush_req, 1'b0, "R7 flush not before third edge");
        wait_n(1);
        chk(flush_req, 1'b1, "R7 flush requested");
        off_req = 0;
        core_wfi = 1;
        wait_n(5);
        chk(flush_req, 1'b1, "R8 flush held without done");
        chk(no_op, 1'b0, "R8 no_op low without flush done");
        fdone = 1;
        wait_n(1);
        fdone = 0;
        chk(flush_req, 1'b0, "R8 flush drops after done");
        chk(no_op, 1'b0, "R8 no_op not yet");
        wait_n(1);
        chk(no_op, 1'b1, "R8 no_op after idle");
        wait_n(5);
        chk(no_op, 1'b1, "R8 no_op held awaiting ack");
        off_ack = 1;
        wait_n(3);
        off_ack = 0;
        off_req = 1;
        wait_n(5);
        chk(no_op, 1'b1, "R10 no_op held when off");
        chk(flush_req, 1'b0, "R10 off request ignored when off");
        off_req = 0;
        wait_n(3);
        on_req = 1;
        wait_n(3);
        chk(no_op, 1'b0, "R10 no_op drops on power-on request");
        on_req = 0;
        off_req = 1;
        wait_n(4);
        chk(flush_req, 1'b0, "R10 off request ignored before on ack");
        off_req = 0;
        wait_n(3);
        on_ack = 1;
        wait_n(3);
        on_ack = 0;
        wait_n(3);
        chk(flush_req, 1'b0, "R10 running after on ack");
        chk(no_op, 1'b0, "R10 no_op low after on ack");
        core_wfi = 0;
        wait_n(4);
        off_req = 1;
        wait_n(3);
        chk(flush_req, 1'b1, "R10 new power-off accepted after on ack");
        off_req = 0;
        irq = 1;
        wait_n(3);
        irq = 0;
        wait_n(4);
    endtask

    task automatic t_abort;
        off_req = 1;
        wait_n(3);
        chk(flush_req, 1'b1, "R9 flush started");
        off_req = 0;
        irq = 1;
        wait_n(3);
        chk(flush_req, 1'b0, "R9 irq aborts flush");
        chk(no_op, 1'b0, "R9 no_op low after flush abort");
        irq = 0;
        wait_n(4);
        chk(flush_req, 1'b0, "R9 back to running");
        off_req = 1;
        wait_n(3);
        off_req = 0;
        fdone = 1;
        wait_n(1);
        fdone = 0;
        chk(flush_req, 1'b0, "R9 in idle wait");
        wait_n(3);
        core_wfi = 1;
        flit[0] = 1'b1;
        wait_n(3);
        chk(no_op, 1'b0, "R9 collision: wake beats idle");
        chk(clk_en, 1'b1, "R9 collision: clock kept on");
        wait_n(4);
        chk(no_op, 1'b0, "R9 no_op never rises after abort");
        flit[0] = 1'b0;
        core_wfi = 0;
        wait_n(5);
    endtask

    initial begin
        t_reset();
        t_gate_irq();
        t_traffic();
        t_debug();
        t_powerdown();
        t_abort();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule